// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This datapath takes two packed integer vectors and reduces each pair of neighbouring elements inside the same operand to one element. The reduction is a sum or a difference. The pair results from operand A are packed into the low part of the destination, and the pair results from operand B are packed directly above them. The unit can wrap on overflow, or it can clamp to the signed 16-bit range.

Two selects set the shape of the operation. `wide_elem` picks 16-bit or 32-bit elements, and `half_vec` picks a 128-bit or 64-bit vector. A request is presented with `in_valid` high. The result and `out_valid` appear on the next clock cycle.

Top module: `hpair_unit`

## Requirements
- R1: Operation code `op_sel` is encoded as follows: 2'b00 add, 2'b01 subtract, 2'b10 saturating add, 2'b11 saturating subtract. In 128-bit, 16-bit mode, output lane k (bits 16k+15:16k) carries the following values:
  - for k = 0..3, the pair result of A elements 2k and 2k+1;
  - for k = 4..7, the pair result of B elements 2(k-4) and 2(k-4)+1.
- R2: A difference is the lower-indexed element of the pair minus the higher-indexed element.
- R3: Add (2'b00) and subtract (2'b01) wrap modulo 2^element width.
- R4: In a saturating 16-bit operation, a true result above 32767 gives 16'h7FFF.
- R5: In a saturating 16-bit operation, a true result below -32768 gives 16'h8000.
- R6: `wide_elem`=1 selects 32-bit elements. Output lanes 0..1 hold the A pairs and lanes 2..3 hold the B pairs. Saturating codes in this mode act as the wrapping add or subtract.
- R7: `half_vec`=1 selects the 64-bit vector. Only bits 63:0 of each operand are used. The A results fill the low 32 bits and the B results fill bits 63:32. Result bits 127:64 are zero.
- R8: `out_valid` is high in the cycle after `in_valid` was high, and low otherwise. The result is registered with one cycle of latency.
- R9: Reset clears `result` and `out_valid`. While `in_valid` is low, `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 128 | First operand; its results go to the low part |
| op_b | input | 128 | Second operand; its results go to the high part |
| op_sel | input | 2 | Operation code |
| wide_elem | input | 1 | 1 = 32-bit elements, 0 = 16-bit |
| half_vec | input | 1 | 1 = 64-bit vector, 0 = 128-bit |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered packed result |

## Verification
The only state in the unit is the result register and its valid flag. A fault in lane routing, pair order or clamping therefore appears at the ports one cycle after the offending request. It shows up as a wrong value in one specific output lane, and that lane identifies the operand half and the pair. A register that updates without a request shows as a changed `result` during idle cycles. A dropped or stretched valid shows as an `out_valid` mismatch on the cycle that follows the strobe.

// File: rtl/hpair_unit.sv
module hpair_unit #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [1:0]       op_sel,
  input  logic             wide_elem,
  input  logic             half_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);

  localparam int L16 = VEC_W / 16;
  localparam int L32 = VEC_W / 32;

  function automatic logic [15:0] lane16(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                                         input logic [1:0] op, input logic half, input int k);
    int p;
    int j;
    logic [VEC_W-1:0] s;
    logic signed [16:0] x, y, r;
    p = half ? L16 / 4 : L16 / 2;
    if (k >= 2 * p) return '0;
    s = (k < p) ? a : b;
    j = (k < p) ? k : k - p;
    x = {s[j*32+15], s[j*32 +: 16]};
    y = {s[j*32+31], s[j*32+16 +: 16]};
    r = op[0] ? x - y : x + y;
    if (op[1]) begin
      if (r > 17'sd32767) return 16'h7FFF;
      if (r < -17'sd32768) return 16'h8000;
    end
    return r[15:0];
  endfunction

  function automatic logic [31:0] lane32(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                                         input logic sub, input logic half, input int k);
    int p;
    int j;
    logic [VEC_W-1:0] s;
    p = half ? L32 / 4 : L32 / 2;
    if (k >= 2 * p) return '0;
    s = (k < p) ? a : b;
    j = (k < p) ? k : k - p;
    return sub ? s[j*64 +: 32] - s[j*64+32 +: 32] : s[j*64 +: 32] + s[j*64+32 +: 32];
  endfunction

  logic [VEC_W-1:0] nxt16, nxt32;

  always_comb begin
    nxt16 = '0;
    nxt32 = '0;
    for (int k = 0; k < L16; k++) nxt16[k*16 +: 16] = lane16(op_a, op_b, op_sel, half_vec, k);
    for (int k = 0; k < L32; k++) nxt32[k*32 +: 32] = lane32(op_a, op_b, op_sel[0], half_vec, k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= wide_elem ? nxt32 : nxt16;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R9
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_vec) |=> (result[VEC_W-1:VEC_W/2] == '0)); // R7
  AST_SAT_ADD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b10 && !wide_elem && !op_a[15] && !op_a[31]) |=> !result[15]); // R4
  AST_SAT_ADD_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b10 && !wide_elem && op_a[15] && op_a[31]) |=> result[15]); // R5

endmodule

// File: tb/hpair_unit_tb.sv
module hpair_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   op_sel = '0;
  logic         wide_elem = 1'b0, half_vec = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hpair_unit dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
                    .op_sel(op_sel), .wide_elem(wide_elem), .half_vec(half_vec),
                    .out_valid(out_valid), .result(result));

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] op, input logic w, input logic h);
    logic [127:0] r = '0;
    int n, p;
    n = (h ? 64 : 128) / (w ? 32 : 16);
    p = n / 2;
    for (int k = 0; k < 2 * p; k++) begin
      logic [127:0] s = (k < p) ? a : b;
      int j = k % p;
      if (w) begin
        longint x = longint'($signed(s[64*j +: 32]));
        longint y = longint'($signed(s[64*j+32 +: 32]));
        longint v = op[0] ? x - y : x + y;
        r[32*k +: 32] = v[31:0];
      end else begin
        int x = int'($signed(s[32*j +: 16]));
        int y = int'($signed(s[32*j+16 +: 16]));
        int v = op[0] ? x - y : x + y;
        if (op[1] && v > 32767) v = 32767;
        if (op[1] && v < -32768) v = -32768;
        r[16*k +: 16] = v[15:0];
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                     input logic [1:0] op, input logic w, input logic h);
    logic [127:0] exp = model(a, b, op, w, h);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; wide_elem = w; half_vec = h; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {127'b0, out_valid}, 128'd1);
    check(tag, result, exp);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check("R9 reset valid", {127'b0, out_valid}, 128'd0);
    check("R9 reset result", result, '0);
    rst_n = 1'b1;

    run("R1 add", {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1,
                   16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10}[127:0] ^ 128'h0,
        128'h0, 2'b00, 1'b0, 1'b0);
    run("R1 layout", 128'h0008_0007_0006_0005_0004_0003_0002_0001,
                     128'h0080_0070_0060_0050_0040_0030_0020_0010, 2'b00, 1'b0, 1'b0);
    check("R1 lane4", {112'b0, result[79:64]}, 128'h30);
    run("R2 order", 128'h0003_0005, 128'h0, 2'b01, 1'b0, 1'b0);
    check("R2 lane0", {112'b0, result[15:0]}, 128'h0002);
    run("R3 wrap", 128'h0001_7FFF, 128'h0, 2'b00, 1'b0, 1'b0);
    check("R3 lane0", {112'b0, result[15:0]}, 128'h8000);
    run("R4 sat add", 128'h0001_7FFF, 128'h0, 2'b10, 1'b0, 1'b0);
    check("R4 lane0", {112'b0, result[15:0]}, 128'h7FFF);
    run("R4 sat sub", 128'hFFFF_7FFF, 128'h0, 2'b11, 1'b0, 1'b0);
    check("R4 sub lane0", {112'b0, result[15:0]}, 128'h7FFF);
    run("R5 sat add", 128'hFFFF_8000, 128'h0, 2'b10, 1'b0, 1'b0);
    check("R5 lane0", {112'b0, result[15:0]}, 128'h8000);
    run("R5 sat sub", 128'h0001_8000, 128'h0, 2'b11, 1'b0, 1'b0);
    check("R5 sub lane0", {112'b0, result[15:0]}, 128'h8000);
    run("R6 sat32 wraps", 128'h00000001_7FFFFFFF, 128'h0, 2'b10, 1'b1, 1'b0);
    check("R6 lane0", {96'b0, result[31:0]}, 128'h80000000);
    run("R7 half", {64'hFFFF_FFFF_FFFF_FFFF, 64'h0004_0003_0002_0001},
                   {64'hAAAA_AAAA_AAAA_AAAA, 64'h0040_0030_0020_0010}, 2'b00, 1'b0, 1'b1);
    check("R7 upper zero", {64'b0, result[127:64]}, 128'h0);

    held = result;
    @(negedge clk);
    op_a = '1; op_b = '1; op_sel = 2'b01;
    @(negedge clk);
    check("R8 idle valid", {127'b0, out_valid}, 128'd0);
    check("R9 hold", result, held);

    for (int i = 0; i < 400; i++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      logic [1:0] op = 2'($urandom);
      logic w = 1'($urandom);
      logic h = 1'($urandom);
      string tag = h ? "R7 rand" : w ? "R6 rand" : op[1] ? "R4 rand" : op[0] ? "R2 rand" : "R1 rand";
      run(tag, a, b, op, w, h);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule